// File: doc/BRIEF.md
# Multi-Pass SAR Conversion Sequencer and Accumulator

This block is the digital side of a 10-bit successive-approximation converter. It runs the track phase, then drives a trial code to an external DAC one bit per clock, most significant bit first. It reads back a single comparator decision for each trial and keeps or drops the bit. Every finished conversion of a burst is added into a wide sum. When the burst completes, the sum is published as the result and a one-cycle done pulse is raised.

In the extended-resolution mode, conversions are grouped into sets of four passes. Each pass of a set selects a different reference index and rotates which of the four largest DAC elements stand for the two upper code bits. This spreads element mismatch across the set. Four 10-bit passes add up to at most 4092. The input can be tracked once per set and held across all four passes, or tracked before every pass. A short mode resolves only the upper eight bits and finishes two clocks earlier.

Top module: `sar_multipass_seq`

## Requirements
- R1: While reset is asserted, busy, done and track are 0, dac_code is 0 and result is 0.
- R2: A conversion takes exactly 10 clocks with bit trials MSB first, one per clock. During a trial, dac_code equals the bits kept so far plus the current trial bit. The bit is kept when cmp_in is 1, so the converted value is the largest code not above the input level.
- R3: Before each conversion that needs a track phase, track is high for exactly cfg_track_len + 1 clocks, for any setting from 0 to 63. Normal mode always tracks before each conversion.
- R4: With cfg_short = 1 and cfg_ext = 0, a conversion takes 8 trial clocks, and the two low bits of every converted value are 00.
- R5: In extended mode, ref_sel and elem_rot both step 0, 1, 2, 3 across the four passes of a set and are 0 when a set begins. In normal mode both stay 0. cfg_short has no effect in extended mode.
- R6: The number of conversions summed is as follows. In normal mode it is cfg_repeat, with 0 taken as 1. In extended mode the two low bits of cfg_repeat are ignored and a value below 4 is taken as 4. All converted values of a burst are added, so one set never exceeds 4092.
- R7: In extended mode with cfg_hold_once = 1, each set has one track phase, before its first pass. With cfg_hold_once = 0, a track phase precedes every pass.
- R8: During a trial, msb_elems holds n ones, where n is the value of dac_code[9:8]. The ones fill slots 0 up to n-1, rotated left by elem_rot.
- R9: A start pulse while busy is ignored. Configuration inputs are captured only when a start is accepted, so later changes do not affect the running burst.
- R10: done is high for exactly one clock, the clock after the final decision of the burst. result changes only in that clock and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit trial per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst when idle |
| cfg_ext | input | 1 | Extended mode: sets of four passes |
| cfg_short | input | 1 | Resolve only the upper 8 bits (normal mode) |
| cfg_hold_once | input | 1 | Extended mode: track once per set |
| cfg_track_len | input | 6 | Track clocks minus one |
| cfg_repeat | input | 6 | Conversions per burst |
| cmp_in | input | 1 | Comparator: input at or above trial level |
| dac_code | output | 10 | Trial code to the DAC, 0 outside trials |
| msb_elems | output | 4 | Rotated enables of the four largest elements |
| ref_sel | output | 2 | Reference selection for the current pass |
| elem_rot | output | 2 | Element rotation index for the current pass |
| track | output | 1 | Track phase active |
| result | output | 16 | Sum of the last completed burst |
| done | output | 1 | One-cycle burst completion pulse |
| busy | output | 1 | Burst in progress |

## Verification
A wrong bit index or code register shows up as a dac_code mismatch in the very next trial clock. It then shows in the result at the burst's end. A slipped pass counter shows as a wrong ref_sel or msb_elems in the first trial of the following pass, long before the summed result is wrong. A miscounted track timer or an off-by-one conversion count moves the falling edge of track or busy by at least a cycle, and the bench compares both on every clock. Bench levels are offset per reference index and the input ramps, so a held sample that was taken at the wrong time changes the sum.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRACK = 2'd1,
    PH_CONV  = 2'd2
  } phase_t;

  // Thermometer of 'cnt' ones in four slots, rotated left by 'rot'.
  function automatic logic [3:0] elem_pattern(input logic [1:0] cnt,
                                              input logic [1:0] rot);
    logic [3:0] therm;
    logic [7:0] twice;
    case (cnt)
      2'd0:    therm = 4'b0000;
      2'd1:    therm = 4'b0001;
      2'd2:    therm = 4'b0011;
      default: therm = 4'b0111;
    endcase
    twice = {therm, therm} << rot;
    return twice[7:4];
  endfunction

endpackage

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int RES_W   = 10,
  parameter int SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_begin,
  input  logic             conv_active,
  input  logic             short_mode,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] conv_value,
  output logic             bit_last
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] MSB_IDX    = IDX_W'(RES_W - 1);
  localparam logic [IDX_W-1:0] SHORT_STOP = IDX_W'(RES_W - SHORT_W);

  logic [RES_W-1:0] code_q;
  logic [RES_W-1:0] trial_bit;
  logic [IDX_W-1:0] bit_idx_q;

  assign trial_bit  = RES_W'(1) << bit_idx_q;
  assign bit_last   = (bit_idx_q == (short_mode ? SHORT_STOP : '0));
  assign conv_value = cmp_in ? (code_q | trial_bit) : code_q;
  assign dac_code   = conv_active ? (code_q | trial_bit) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= '0;
      bit_idx_q <= MSB_IDX;
    end else if (conv_begin) begin
      code_q    <= '0;
      bit_idx_q <= MSB_IDX;
    end else if (conv_active) begin
      code_q <= conv_value;
      if (!bit_last) bit_idx_q <= bit_idx_q - 1'b1;
    end
  end

  // R2: trials walk down one bit per clock
  assert_bit_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_active && !bit_last && !conv_begin |=> bit_idx_q == $past(bit_idx_q) - 1'b1);

  // R4: short conversions leave the unresolved low bits clear
  assert_short_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_active && bit_last && short_mode |-> conv_value[RES_W-SHORT_W-1:0] == '0);

endmodule

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
  import sar_seq_pkg::*;
#(
  parameter int TRK_W = 6,
  parameter int REP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_ext,
  input  logic             cfg_short,
  input  logic             cfg_hold_once,
  input  logic [TRK_W-1:0] cfg_track_len,
  input  logic [REP_W-1:0] cfg_repeat,
  input  logic             bit_last,
  output logic             busy,
  output logic             track,
  output logic             conv_active,
  output logic             conv_begin,
  output logic             conv_fire,
  output logic             burst_start,
  output logic             burst_end,
  output logic             short_mode,
  output logic [1:0]       pass_idx
);
  phase_t           state_q;
  logic             ext_q, short_q, hold_q;
  logic [TRK_W-1:0] tlen_q, trk_cnt_q;
  logic [REP_W-1:0] left_q;
  logic [1:0]       pass_idx_q;
  logic             track_done;
  logic             skip_track;

  function automatic logic [REP_W-1:0] eff_convs(input logic ext,
                                                 input logic [REP_W-1:0] rep);
    logic [REP_W-1:0] set_base;
    set_base = {rep[REP_W-1:2], 2'b00};
    if (ext) return (set_base == '0) ? REP_W'(4) : set_base;
    return (rep == '0) ? REP_W'(1) : rep;
  endfunction

  assign burst_start = (state_q == PH_IDLE) && start;
  assign track_done  = (state_q == PH_TRACK) && (trk_cnt_q == tlen_q);
  assign conv_active = (state_q == PH_CONV);
  assign conv_fire   = conv_active && bit_last;
  assign burst_end   = conv_fire && (left_q == REP_W'(1));
  assign skip_track  = ext_q && hold_q && (pass_idx_q != 2'd3);
  assign conv_begin  = track_done || (conv_fire && !burst_end && skip_track);

  assign busy       = (state_q != PH_IDLE);
  assign track      = (state_q == PH_TRACK);
  assign short_mode = short_q && !ext_q;
  assign pass_idx   = pass_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PH_IDLE;
      ext_q      <= 1'b0;
      short_q    <= 1'b0;
      hold_q     <= 1'b0;
      tlen_q     <= '0;
      trk_cnt_q  <= '0;
      left_q     <= '0;
      pass_idx_q <= 2'd0;
    end else begin
      case (state_q)
        PH_IDLE: if (start) begin
          ext_q      <= cfg_ext;
          short_q    <= cfg_short;
          hold_q     <= cfg_hold_once;
          tlen_q     <= cfg_track_len;
          left_q     <= eff_convs(cfg_ext, cfg_repeat);
          pass_idx_q <= 2'd0;
          trk_cnt_q  <= '0;
          state_q    <= PH_TRACK;
        end
        PH_TRACK: begin
          if (track_done) begin
            trk_cnt_q <= '0;
            state_q   <= PH_CONV;
          end else begin
            trk_cnt_q <= trk_cnt_q + 1'b1;
          end
        end
        PH_CONV: if (conv_fire) begin
          left_q     <= left_q - 1'b1;
          pass_idx_q <= ext_q ? pass_idx_q + 2'd1 : 2'd0;
          if (burst_end)        state_q <= PH_IDLE;
          else if (!skip_track) state_q <= PH_TRACK;
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  // R5: normal mode never leaves reference / rotation index 0
  assert_normal_pass_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ext_q |-> pass_idx_q == 2'd0);

  // R7: held sample skips track within a set, otherwise a track phase follows
  assert_hold_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fire && !burst_end && ext_q && hold_q && pass_idx_q != 2'd3 |=> conv_active);
  assert_retrack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fire && !burst_end && !(ext_q && hold_q) |=> track);

  // R9: a start during a burst does not reload the captured configuration
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(ext_q) && $stable(tlen_q) && $stable(short_q) && $stable(hold_q));

endmodule

// File: rtl/sar_accum.sv
module sar_accum #(
  parameter int RES_W = 10,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_start,
  input  logic             conv_fire,
  input  logic             burst_end,
  input  logic [RES_W-1:0] conv_value,
  output logic [ACC_W-1:0] result,
  output logic             done
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   acc_wide;

  assign acc_wide = {1'b0, acc_q} + (ACC_W + 1)'(conv_value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= burst_end;
      if (burst_start)    acc_q <= '0;
      else if (conv_fire) acc_q <= acc_wide[ACC_W-1:0];
      if (burst_end)      result <= acc_wide[ACC_W-1:0];
    end
  end

  // R6: the sum never exceeds the accumulator width
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fire |-> acc_wide[ACC_W] == 1'b0);

  // R10: done lasts one clock and the result moves only with it
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

// File: rtl/dem_elem_map.sv
module dem_elem_map
  import sar_seq_pkg::*;
(
  input  logic [1:0] code_top,
  input  logic [1:0] rot,
  output logic [3:0] elems
);
  always_comb begin
    elems = elem_pattern(code_top, rot);
    if (!$isunknown(code_top)) begin
      // R8: rotation keeps the number of enabled elements
      assert_elem_count_R8: assert ($countones(elems) == int'(code_top));
    end
  end
endmodule

// File: rtl/sar_multipass_seq.sv
module sar_multipass_seq #(
  parameter int RES_W   = 10,
  parameter int SHORT_W = 8,
  parameter int TRK_W   = 6,
  parameter int REP_W   = 6,
  localparam int ACC_W  = RES_W + REP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_ext,
  input  logic             cfg_short,
  input  logic             cfg_hold_once,
  input  logic [TRK_W-1:0] cfg_track_len,
  input  logic [REP_W-1:0] cfg_repeat,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [3:0]       msb_elems,
  output logic [1:0]       ref_sel,
  output logic [1:0]       elem_rot,
  output logic             track,
  output logic [ACC_W-1:0] result,
  output logic             done,
  output logic             busy
);
  logic             conv_active, conv_begin, conv_fire;
  logic             burst_start, burst_end;
  logic             short_mode, bit_last;
  logic [1:0]       pass_idx;
  logic [RES_W-1:0] conv_value;

  sar_phase_ctrl #(.TRK_W(TRK_W), .REP_W(REP_W)) u_ctrl (
    .clk, .rst_n, .start, .cfg_ext, .cfg_short, .cfg_hold_once,
    .cfg_track_len, .cfg_repeat, .bit_last,
    .busy, .track, .conv_active, .conv_begin, .conv_fire,
    .burst_start, .burst_end, .short_mode, .pass_idx
  );

  sar_bit_engine #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_engine (
    .clk, .rst_n, .conv_begin, .conv_active, .short_mode, .cmp_in,
    .dac_code, .conv_value, .bit_last
  );

  sar_accum #(.RES_W(RES_W), .ACC_W(ACC_W)) u_accum (
    .clk, .rst_n, .burst_start, .conv_fire, .burst_end, .conv_value,
    .result, .done
  );

  dem_elem_map u_dem (
    .code_top (dac_code[RES_W-1 -: 2]),
    .rot      (pass_idx),
    .elems    (msb_elems)
  );

  assign ref_sel  = pass_idx;
  assign elem_rot = pass_idx;

endmodule

// File: tb/sar_multipass_seq_tb_top.sv
module sar_multipass_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_ext = 1'b0, cfg_short = 1'b0, cfg_hold_once = 1'b0;
  logic [5:0]  cfg_track_len = '0;
  logic [5:0]  cfg_repeat = '0;
  logic        cmp_in;
  logic [9:0]  dac_code;
  logic [3:0]  msb_elems;
  logic [1:0]  ref_sel, elem_rot;
  logic        track, done, busy;
  logic [15:0] result;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, t0 = 0, ain_base = 0, ain_step = 0, held_dut = 0;

  // reference model state
  int m_phase = 0, m_cnt = 0, m_bit = 9, m_code = 0, m_left = 0, m_pass = 0;
  int m_acc = 0, m_result = 0, m_held = 0, m_tl = 0;
  bit m_done = 0, m_ext = 0, m_sh = 0, m_hold = 0;

  always #4 clk = ~clk;

  function automatic int level(int h, int k);
    int v;
    v = h + 300 * k;
    if (v > 1023) v = 1023;
    if (v < 0) v = 0;
    return v;
  endfunction

  function automatic int ain_now();
    return ain_base + ain_step * (cyc - t0);
  endfunction

  assign cmp_in = (level(held_dut, int'(ref_sel)) >= int'(dac_code));

  sar_multipass_seq dut_i (
    .clk, .rst_n, .start, .cfg_ext, .cfg_short, .cfg_hold_once,
    .cfg_track_len, .cfg_repeat, .cmp_in, .dac_code, .msb_elems,
    .ref_sel, .elem_rot, .track, .result, .done, .busy
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int trial, stop;
    m_done = 0;
    case (m_phase)
      0: if (start) begin
        m_ext = cfg_ext; m_sh = cfg_short; m_hold = cfg_hold_once;
        m_tl = int'(cfg_track_len);
        m_left = m_ext ? (int'(cfg_repeat) / 4) * 4 : int'(cfg_repeat);
        if (m_ext && m_left < 4) m_left = 4;
        if (!m_ext && m_left == 0) m_left = 1;
        m_pass = 0; m_acc = 0; m_cnt = 0; m_phase = 1;
      end
      1: begin
        m_held = ain_now();
        if (m_cnt == m_tl) begin m_phase = 2; m_code = 0; m_bit = 9; m_cnt = 0; end
        else m_cnt++;
      end
      default: begin
        trial = m_code + (1 << m_bit);
        if (level(m_held, m_pass) >= trial) m_code = trial;
        stop = (m_sh && !m_ext) ? 2 : 0;
        if (m_bit == stop) begin
          m_acc += m_code;
          m_left--;
          m_pass = m_ext ? (m_pass + 1) % 4 : 0;
          if (m_left == 0) begin m_result = m_acc; m_done = 1; m_phase = 0; end
          else if (m_ext && m_hold && m_pass != 0) begin m_code = 0; m_bit = 9; end
          else m_phase = 1;
        end else m_bit--;
      end
    endcase
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (track) held_dut <= ain_now();
    if (!rst_n) begin
      m_phase = 0; m_pass = 0; m_result = 0; m_done = 0; m_acc = 0;
    end else model_step();
  end

  function automatic int exp_elems(int code, int rot);
    int n, r;
    n = code / 256; r = 0;
    for (int s = 0; s < 4; s++) if (((s - rot + 4) % 4) < n) r |= (1 << s);
    return r;
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n) begin
    int edac;
    edac = (m_phase == 2) ? m_code + (1 << m_bit) : 0;
    check("R9", "busy", int'(busy), int'(m_phase != 0));
    check("R3", "track", int'(track), int'(m_phase == 1));
    check("R10", "done", int'(done), int'(m_done));
    check("R10", "result", int'(result), m_result);
    check("R5", "ref_sel", int'(ref_sel), m_pass);
    check("R5", "elem_rot", int'(elem_rot), m_pass);
    check("R2", "dac_code", int'(dac_code), edac);
    check("R8", "msb_elems", int'(msb_elems), exp_elems(edac, m_pass));
  end

  function automatic int exp_sum(bit ext, bit sh, int rep, int base);
    int n, s, v;
    n = ext ? (rep / 4) * 4 : rep;
    if (ext && n < 4) n = 4;
    if (!ext && n == 0) n = 1;
    s = 0;
    for (int i = 0; i < n; i++) begin
      v = level(base, ext ? i % 4 : 0);
      if (sh && !ext) v = (v / 4) * 4;
      s += v;
    end
    return s;
  endfunction

  task automatic run_burst(input string req, input bit ext, input bit sh, input bit hold,
                           input int tlen, input int rep, input int base, input int step,
                           input int exp_busy, input int poke);
    int bc, dc, res;
    bit seen;
    @(posedge clk); #2;
    cfg_ext = ext; cfg_short = sh; cfg_hold_once = hold;
    cfg_track_len = 6'(tlen); cfg_repeat = 6'(rep);
    ain_base = base; ain_step = step; t0 = cyc; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    bc = 0; dc = 0; res = 0; seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (busy) bc++;
      if (done) begin dc++; seen = 1; res = int'(result); end
      if (poke >= 0 && i == poke) begin
        start = 1'b1; cfg_ext = ~ext; cfg_short = ~sh; cfg_track_len = 6'(tlen + 7);
      end
      if (poke >= 0 && i == poke + 1) begin
        start = 1'b0; cfg_ext = ext; cfg_short = sh; cfg_track_len = 6'(tlen);
      end
    end
    @(negedge clk);
    if (done) dc++;
    check("R10", "done cycles", dc, 1);
    if (exp_busy >= 0) check(req, "busy cycles", bc, exp_busy);
    if (step == 0) check(req, "burst result", res, exp_sum(ext, sh, rep, base));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset track", int'(track), 0);
    check("R1", "reset dac_code", int'(dac_code), 0);
    check("R1", "reset result", int'(result), 0);
    @(posedge clk); #2 rst_n = 1'b1;

    // R2: plain 10-bit conversion, 4 track + 10 trial clocks
    run_burst("R2", 0, 0, 0, 3, 1, 517, 0, 14, -1);
    run_burst("R2", 0, 0, 0, 3, 1, 1023, 0, 14, -1);
    run_burst("R2", 0, 0, 0, 3, 1, 0, 0, 14, -1);
    // R4: short conversions, 8 trial clocks, low bits cleared
    run_burst("R4", 0, 1, 0, 3, 1, 517, 0, 12, -1);
    run_burst("R4", 0, 1, 0, 3, 1, 1023, 0, 12, -1);
    // R3: track length extremes
    run_burst("R3", 0, 0, 0, 0, 1, 300, 0, 11, -1);
    run_burst("R3", 0, 0, 0, 63, 1, 300, 0, 74, -1);
    // R6: repeat counts
    run_burst("R6", 0, 0, 0, 1, 3, 100, 0, 36, -1);
    run_burst("R6", 0, 0, 0, 1, 0, 100, 0, 12, -1);
    run_burst("R6", 1, 0, 1, 0, 4, 1023, 0, 41, -1);
    run_burst("R6", 1, 0, 1, 0, 16, 50, 0, 164, -1);
    run_burst("R6", 1, 0, 1, 0, 5, 200, 0, 41, -1);
    run_burst("R6", 1, 0, 1, 0, 2, 200, 0, 41, -1);
    // R5: cfg_short ignored in extended mode
    run_burst("R5", 1, 1, 1, 2, 4, 517, 0, 43, -1);
    // R7: track once per set versus before every pass
    run_burst("R7", 1, 0, 1, 5, 4, 400, 0, 46, -1);
    run_burst("R7", 1, 0, 0, 5, 4, 400, 0, 64, -1);
    run_burst("R7", 1, 0, 1, 2, 8, 100, 5, 86, -1);
    run_burst("R7", 1, 0, 0, 2, 8, 100, 5, 104, -1);
    // R8: ramping input sweeps the upper code bits in every rotation
    run_burst("R8", 1, 0, 0, 1, 12, 0, 9, 144, -1);
    // R9: start and configuration changes during a burst are ignored
    run_burst("R9", 1, 0, 1, 3, 8, 333, 0, 88, 10);
    run_burst("R9", 0, 0, 0, 3, 2, 640, 0, 28, 5);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule